// File: doc/BRIEF.md
# I2C Bit-Rate and SDA-Hold Generator

This block turns the system bus clock into the timing pulses that an I2C master needs to drive its serial clock line. An 8-bit rate setting holds a scale field in bits 7:6 and an index field in bits 5:0. The index selects one of 64 base divider values and, with it, a data hold count. The scale field multiplies the divider. The block emits a one-cycle pulse when the master should release SCL (end of the low half), a pulse when it should pull SCL low (end of the high half), and a pulse that marks the point after each falling edge where SDA may be changed.

The base divider for index `i` is `20 + 4*i`, so the fastest rate is the bus clock divided by 20. The hold count is `4 + i` bus clocks and is not scaled. Index 5 therefore gives a divider of 40 with a hold of 9. Each half period lasts `scale * divider / 2` bus clocks. The high-half count only advances while SCL is sensed high. This lets a slave or another master stretch or synchronise the clock. The rate setting is captured only when a START is signalled, so a transfer in progress keeps its rate.

Top module: `i2c_rate_gen`

## Requirements
- R1: After reset all three pulse outputs are low. Until the first START the timing uses scale 00 and index 0, giving half period 10 and hold 4.
- R2: With scale 00 (factor 1), the low half lasts `(20 + 4*index)/2` bus clocks, from the falling pulse to the next rising pulse, for every index 0 to 63.
- R3: Scale encodings give factors 00 -> 1, 01 -> 2, 10 -> 4, and 11 -> 1 (reserved). Each half period is `factor * (20 + 4*index) / 2` bus clocks.
- R4: When SCL is sensed high from the cycle after the rising pulse, the falling pulse comes exactly one half period after the rising pulse.
- R5: The high-half count does not advance in a cycle where `scl_in` is low. The falling pulse never follows a cycle with `scl_in` low, and each extra low cycle delays it by one bus clock.
- R6: `sda_chg_o` pulses exactly `4 + index` bus clocks after each falling pulse, independent of the scale factor.
- R7: A change on `freq_reg` without `start_req` has no effect on the timing. The latched rate changes only in a cycle that samples `start_req` high.
- R8: `start_req` sampled with `en` high restarts the timing in the high half. The first falling pulse comes one half period after that edge while SCL stays high.
- R9: While `en` is low, all three pulse outputs stay low from the cycle after `en` is sampled low.
- R10: At most one of the three pulse outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Master owns the clock line; low idles the generator |
| start_req | input | 1 | START strobe; captures `freq_reg` and restarts timing |
| freq_reg | input | 8 | Rate setting: [7:6] scale, [5:0] index |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_rise_o | output | 1 | Pulse: release SCL (end of low half) |
| scl_fall_o | output | 1 | Pulse: drive SCL low (end of high half) |
| sda_chg_o | output | 1 | Pulse: SDA may change now |

## Verification
Every cycle, the assertions check that the pulses are mutually exclusive, that the generator is silent while disabled, and that the latched rate holds steady between START strobes. They also check that a falling pulse only follows a cycle with SCL sensed high and that a rise is never followed at once by a fall. The exact lengths can only be shown by the bench scenarios, which measure each edge-to-edge distance in bus clocks across several index and scale values. These are the low and high half lengths for each scale encoding, the hold delay, the extra delay from a stretched SCL, and the first fall after a START.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;
  localparam int IDX_W     = 6;
  localparam int MUL_W     = 2;
  localparam int DIV_BASE  = 20;
  localparam int DIV_STEP  = 4;
  localparam int HOLD_BASE = 4;
  localparam int HOLD_STEP = 1;
  localparam int MAX_DIV   = DIV_BASE + DIV_STEP * ((1 << IDX_W) - 1);
  localparam int MAX_HALF  = (4 * MAX_DIV) / 2;
  localparam int CNT_W     = $clog2(MAX_HALF + 1);
  localparam int MAX_HOLD  = HOLD_BASE + HOLD_STEP * ((1 << IDX_W) - 1);
  localparam int HOLD_W    = $clog2(MAX_HOLD + 1);

  typedef enum logic [MUL_W-1:0] {
    MUL_X1  = 2'b00,
    MUL_X2  = 2'b01,
    MUL_X4  = 2'b10,
    MUL_RSV = 2'b11
  } mul_sel_e;

  typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;

  typedef struct packed {
    logic [CNT_W-1:0]  half;
    logic [HOLD_W-1:0] hold;
  } rate_cfg_t;
endpackage

// File: rtl/i2c_rate_lookup.sv
module i2c_rate_lookup
  import i2c_rate_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int MW = MUL_W
) (
  input  logic [IW-1:0] idx,
  input  logic [MW-1:0] mul,
  output rate_cfg_t     cfg
);
  logic [CNT_W-1:0] base_div;

  // divider and hold are affine in the index, so no stored table is needed
  always_comb begin
    base_div = CNT_W'(DIV_BASE) + CNT_W'(DIV_STEP) * CNT_W'(idx);
    case (mul_sel_e'(mul))
      MUL_X2:  cfg.half = base_div;
      MUL_X4:  cfg.half = base_div << 1;
      default: cfg.half = base_div >> 1;
    endcase
    cfg.hold = HOLD_W'(HOLD_BASE) + HOLD_W'(HOLD_STEP) * HOLD_W'(idx);
  end
endmodule

// File: rtl/i2c_rate_cfg_reg.sv
module i2c_rate_cfg_reg
  import i2c_rate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  rate_cfg_t cfg_in,
  output rate_cfg_t cfg_q
);
  localparam logic [CNT_W-1:0]  RST_HALF = CNT_W'(DIV_BASE / 2);
  localparam logic [HOLD_W-1:0] RST_HOLD = HOLD_W'(HOLD_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.half <= RST_HALF;
      cfg_q.hold <= RST_HOLD;
    end else if (load) begin
      cfg_q <= cfg_in;
    end
  end
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer
  import i2c_rate_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          restart,
  input  logic          scl_in,
  input  logic [CW-1:0] half,
  output logic          rise_o,
  output logic          fall_o
);
  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == half - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_HIGH;
      cnt    <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (!en || restart) begin
        ph  <= PH_HIGH;
        cnt <= '0;
      end else if (ph == PH_LOW) begin
        if (last) begin
          ph     <= PH_HIGH;
          cnt    <= '0;
          rise_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (scl_in) begin
        // high half advances only while the line is really high
        if (last) begin
          ph     <= PH_LOW;
          cnt    <= '0;
          fall_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_hold_timer.sv
module i2c_hold_timer
  import i2c_rate_pkg::*;
#(
  parameter int HW = HOLD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          restart,
  input  logic          fire,
  input  logic [HW-1:0] hold,
  output logic          sda_o
);
  logic [HW-1:0] hcnt;
  logic          busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt  <= '0;
      busy  <= 1'b0;
      sda_o <= 1'b0;
    end else begin
      sda_o <= 1'b0;
      if (!en || restart) begin
        busy <= 1'b0;
      end else if (fire) begin
        // fire is seen one clock late, so load one less
        busy <= 1'b1;
        hcnt <= hold - 1'b1;
      end else if (busy) begin
        if (hcnt == 1) begin
          sda_o <= 1'b1;
          busy  <= 1'b0;
        end else begin
          hcnt <= hcnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen
  import i2c_rate_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int MW = MUL_W,
  localparam int FW = IW + MW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          start_req,
  input  logic [FW-1:0] freq_reg,
  input  logic          scl_in,
  output logic          scl_rise_o,
  output logic          scl_fall_o,
  output logic          sda_chg_o
);
  rate_cfg_t        cfg_next;
  rate_cfg_t        cfg_q;
  logic [CNT_W-1:0] cur_half;
  logic             restart;

  assign restart  = en && start_req;
  assign cur_half = cfg_q.half;

  i2c_rate_lookup #(.IW(IW), .MW(MW)) u_lut (
    .idx (freq_reg[IW-1:0]),
    .mul (freq_reg[FW-1 -: MW]),
    .cfg (cfg_next)
  );

  i2c_rate_cfg_reg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .load   (start_req),
    .cfg_in (cfg_next),
    .cfg_q  (cfg_q)
  );

  i2c_phase_timer #(.CW(CNT_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .restart (restart),
    .scl_in  (scl_in),
    .half    (cur_half),
    .rise_o  (scl_rise_o),
    .fall_o  (scl_fall_o)
  );

  i2c_hold_timer #(.HW(HOLD_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .restart (restart),
    .fire    (scl_fall_o),
    .hold    (cfg_q.hold),
    .sda_o   (sda_chg_o)
  );
endmodule

// File: rtl/i2c_rate_chk.sv
module i2c_rate_chk #(
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          start_req,
  input logic          scl_in,
  input logic          scl_rise_o,
  input logic          scl_fall_o,
  input logic          sda_chg_o,
  input logic [CW-1:0] cur_half
);
  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_rise_o, scl_fall_o, sda_chg_o}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!scl_rise_o && !scl_fall_o && !sda_chg_o));

  assert_rate_held_R7: assert property (@(posedge clk) disable iff (rst)
    !start_req |=> $stable(cur_half));

  assert_fall_needs_high_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_fall_o) |-> $past(scl_in));

  assert_no_short_high_R4: assert property (@(posedge clk) disable iff (rst)
    scl_rise_o |=> !scl_fall_o);
endmodule

bind i2c_rate_gen i2c_rate_chk #(.CW(i2c_rate_pkg::CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .start_req  (start_req),
  .scl_in     (scl_in),
  .scl_rise_o (scl_rise_o),
  .scl_fall_o (scl_fall_o),
  .sda_chg_o  (sda_chg_o),
  .cur_half   (cur_half)
);

// File: tb/sim_i2c_rate_gen.sv
`timescale 1ns/1ps
module sim_i2c_rate_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       start_req = 1'b0;
  logic [7:0] freq_reg = 8'h00;
  logic       scl_in = 1'b1;
  logic       scl_rise_o, scl_fall_o, sda_chg_o;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;
  int stretch = 0;
  int pend = 0;
  int multi_hot = 0;
  bit released = 1'b1;

  always #2.5 clk = ~clk;

  i2c_rate_gen u0 (
    .clk(clk), .rst(rst), .en(en), .start_req(start_req),
    .freq_reg(freq_reg), .scl_in(scl_in),
    .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o), .sda_chg_o(sda_chg_o)
  );

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock; sample 1 ns after the edge, then update the SCL line model
  task automatic step();
    @(posedge clk);
    #1;
    cyc++;
    if ((32'(scl_rise_o) + 32'(scl_fall_o) + 32'(sda_chg_o)) > 1) multi_hot++;
    if (scl_fall_o) released = 1'b0;
    if (scl_rise_o) begin released = 1'b1; pend = stretch; end
    if (released && pend > 0) begin scl_in = 1'b0; pend--; end
    else scl_in = released;
  endtask

  task automatic do_start(input logic [7:0] fr);
    released  = 1'b1;
    scl_in    = 1'b1;
    pend      = 0;
    freq_reg  = fr;
    start_req = 1'b1;
    step();
    start_req = 1'b0;
  endtask

  task automatic measure(input string low_tag, input string high_tag,
                         input int exp_half, input int exp_hold, input int strc);
    int t_fall, t_sda, t_rise, t_fall2, guard;
    guard = 0;
    while (!scl_fall_o && guard < 4000) begin step(); guard++; end
    t_fall = cyc;
    stretch = strc;
    step();
    guard = 0;
    while (!sda_chg_o && guard < 4000) begin step(); guard++; end
    t_sda = cyc;
    guard = 0;
    while (!scl_rise_o && guard < 4000) begin step(); guard++; end
    t_rise = cyc;
    guard = 0;
    while (!scl_fall_o && guard < 4000) begin step(); guard++; end
    t_fall2 = cyc;
    stretch = 0;
    check("R6 hold after fall", t_sda - t_fall, exp_hold);
    check({low_tag, " low half"}, t_rise - t_fall, exp_half);
    check({high_tag, " high half"}, t_fall2 - t_rise, exp_half + strc);
  endtask

  task automatic t_reset();
    int seen = 0;
    for (int i = 0; i < 4; i++) step();
    check("R1 outputs in reset", 32'(scl_rise_o) + 32'(scl_fall_o) + 32'(sda_chg_o), 0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      step();
      seen += 32'(scl_rise_o) + 32'(scl_fall_o) + 32'(sda_chg_o);
    end
    check("R9 quiet while disabled after reset", seen, 0);
    // no START yet: a pending rate setting must not apply; reset rate is 10/4
    freq_reg = 8'h45;
    en = 1'b1;
    measure("R1", "R7", 10, 4, 0);
  endtask

  task automatic t_rates();
    do_start(8'h05); measure("R2", "R4", 20, 9, 0);
    do_start(8'h45); measure("R3 x2", "R4", 40, 9, 0);
    do_start(8'h83); measure("R3 x4", "R4", 64, 7, 0);
    do_start(8'hC2); measure("R3 reserved", "R4", 14, 6, 0);
    do_start(8'h3F); measure("R2 top index", "R4", 136, 67, 0);
    do_start(8'h00); measure("R2 fastest", "R4", 10, 4, 0);
  endtask

  task automatic t_stretch();
    do_start(8'h05);
    measure("R2", "R5 stretched", 20, 9, 7);
  endtask

  task automatic t_start();
    int s, guard;
    do_start(8'h02);
    s = cyc;
    guard = 0;
    while (!scl_fall_o && guard < 4000) begin step(); guard++; end
    check("R8 first fall after START", cyc - s, 14);
  endtask

  task automatic t_midchange();
    do_start(8'h01);
    freq_reg = 8'h3F;
    measure("R7 rate kept", "R7", 12, 5, 0);
    do_start(8'h3F);
    measure("R7 rate after START", "R4", 136, 67, 0);
  endtask

  task automatic t_disable();
    int seen = 0;
    do_start(8'h00);
    for (int i = 0; i < 13; i++) step();
    en = 1'b0;
    step();
    for (int i = 0; i < 40; i++) begin
      step();
      seen += 32'(scl_rise_o) + 32'(scl_fall_o) + 32'(sda_chg_o);
    end
    check("R9 quiet while disabled", seen, 0);
    en = 1'b1;
  endtask

  initial begin
    t_reset();
    t_rates();
    t_stretch();
    t_start();
    t_midchange();
    t_disable();
    check("R10 pulses exclusive", multi_hot, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule